// File: doc/BRIEF.md
# Power-on and Watchdog Reset Supervisor

This block drives a single active-low reset line for a host processor. Three sources share that line: a power-on delay, a hold while the supply-low flag is raised, and a watchdog that bites when the host stops servicing it. Time is counted in quarter-second units of `QUARTER_TICKS` clock cycles. The power-on delay and the watchdog reset pulse are each one unit long. The watchdog timeout is 7, 3 or 1 units, or the watchdog is off, as chosen by a 2-bit select.

The controller is a three-state machine. `ST_DELAY` holds reset and counts one unit. `ST_RUN` releases reset and lets the watchdog count. `ST_BROWN` holds reset while the supply is low. The transitions are:
- DELAY→RUN when the delay timer is done.
- DELAY→BROWN, RUN→BROWN on supply-low.
- BROWN→DELAY once supply-low clears.
- RUN→DELAY on watchdog expiry (the bite).

An asynchronous power-on input puts the machine in `ST_DELAY`. The watchdog counter is cleared in every state except `ST_RUN`.

Top module: `reset_supervisor`

## Requirements
- R1: While `rst_por_n` is low, `host_rst_n` is low. After `rst_por_n` rises, `host_rst_n` stays low for exactly `QUARTER_TICKS` rising clock edges and goes high right after the `QUARTER_TICKS`-th edge.
- R2: A high `supply_low` sampled at a rising edge drives `host_rst_n` low after that edge, and it stays low while `supply_low` stays high.
- R3: When `supply_low` is first sampled low again, the full delay restarts. `host_rst_n` goes high after the `QUARTER_TICKS`-th following edge.
- R4: The select code sets the watchdog timeout: `00` gives 7×`QUARTER_TICKS` cycles, `01` gives 3×, and `10` gives 1×. The timeout is counted from the edge that restarted the count to the edge that asserts reset.
- R5: Select code `11` disables the watchdog, so reset is never asserted by it.
- R6: A `wdt_kick` sampled high at a rising edge restarts the watchdog count from zero.
- R7: A change of `wdt_sel` between two consecutive edges restarts the watchdog count from zero.
- R8: A watchdog bite holds `host_rst_n` low for exactly `QUARTER_TICKS` cycles. After that the watchdog counts again from zero.
- R9: The watchdog does not count while reset is asserted. After the power-on delay, the first bite comes a full timeout after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_por_n | input | 1 | Asynchronous power-on event, active low |
| supply_low | input | 1 | Supply below trip level |
| wdt_kick | input | 1 | Watchdog service strobe |
| wdt_sel | input | 2 | Timeout select: 00=7u, 01=3u, 10=1u, 11=off |
| host_rst_n | output | 1 | Reset to host, active low |

## Verification
The main test is a table of select codes. Each row restarts the watchdog with a kick and then measures the cycles until the bite and the width of the reset pulse. The consecutive codes differ, so a swapped encoding, an off-by-one limit or a broken disable code all show up as a wrong count. Separate tests use a steady kick train to confirm that servicing prevents a bite. They shorten the select partway through a long count, which tells a real restart apart from a counter that overshoots the new limit. They also hold the supply-low flag across a running watchdog and measure the delay that follows its release.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;
    typedef enum logic [1:0] {
        ST_DELAY = 2'd0,
        ST_RUN   = 2'd1,
        ST_BROWN = 2'd2
    } sup_state_e;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;

    localparam int unsigned UNITS_LONG  = 7;
    localparam int unsigned UNITS_MID   = 3;
    localparam int unsigned UNITS_SHORT = 1;
endpackage

// File: rtl/sup_delay_timer.sv
`timescale 1ns/1ps
module sup_delay_timer #(
    parameter int unsigned TICKS = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int unsigned DW = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICKS - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/sup_wdt_timer.sv
`timescale 1ns/1ps
module sup_wdt_timer
    import sup_pkg::*;
#(
    parameter int unsigned UNIT_TICKS = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       kick,
    input  logic [1:0] sel,
    output logic       expire
);
    localparam int unsigned CW = $clog2(UNITS_LONG * UNIT_TICKS);
    localparam logic [CW-1:0] LIM_LONG  = CW'(UNITS_LONG  * UNIT_TICKS - 1);
    localparam logic [CW-1:0] LIM_MID   = CW'(UNITS_MID   * UNIT_TICKS - 1);
    localparam logic [CW-1:0] LIM_SHORT = CW'(UNITS_SHORT * UNIT_TICKS - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit_m1;
    logic [1:0]    sel_q;
    logic          restart;
    logic          disabled;

    always_comb begin
        unique case (sel)
            SEL_LONG:  limit_m1 = LIM_LONG;
            SEL_MID:   limit_m1 = LIM_MID;
            SEL_SHORT: limit_m1 = LIM_SHORT;
            default:   limit_m1 = '0;
        endcase
    end

    assign restart  = kick || (sel != sel_q);
    assign disabled = (sel == SEL_OFF);
    assign expire   = active && !restart && !disabled && (cnt == limit_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SEL_LONG;
            cnt   <= '0;
        end else begin
            sel_q <= sel;
            if (!active || restart || disabled || expire)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/reset_supervisor.sv
`timescale 1ns/1ps
module reset_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned QUARTER_TICKS = 8192
) (
    input  logic       clk,
    input  logic       rst_por_n,
    input  logic       supply_low,
    input  logic       wdt_kick,
    input  logic [1:0] wdt_sel,
    output logic       host_rst_n
);
    sup_state_e state, state_nx;
    logic       dly_done;
    logic       wdt_bite;

    sup_delay_timer #(.TICKS(QUARTER_TICKS)) u_delay (
        .clk   (clk),
        .rst_n (rst_por_n),
        .run   (state == ST_DELAY && !supply_low),
        .done  (dly_done)
    );

    sup_wdt_timer #(.UNIT_TICKS(QUARTER_TICKS)) u_wdt (
        .clk    (clk),
        .rst_n  (rst_por_n),
        .active (state == ST_RUN && !supply_low),
        .kick   (wdt_kick),
        .sel    (wdt_sel),
        .expire (wdt_bite)
    );

    always_ff @(posedge clk or negedge rst_por_n) begin
        if (!rst_por_n)
            state <= ST_DELAY;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DELAY: begin
                if (supply_low)    state_nx = ST_BROWN;
                else if (dly_done) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (supply_low)    state_nx = ST_BROWN;
                else if (wdt_bite) state_nx = ST_DELAY;
            end
            ST_BROWN: begin
                if (!supply_low)   state_nx = ST_DELAY;
            end
            default:               state_nx = ST_DELAY;
        endcase
    end

    always_comb begin
        host_rst_n = (state == ST_RUN);
    end
endmodule

// File: rtl/reset_supervisor_chk.sv
`timescale 1ns/1ps
module reset_supervisor_chk #(
    parameter int unsigned QUARTER_TICKS = 8192
) (
    input logic       clk,
    input logic       rst_por_n,
    input logic       supply_low,
    input logic       wdt_kick,
    input logic [1:0] wdt_sel,
    input logic       host_rst_n
);
    localparam int unsigned LW = $clog2(QUARTER_TICKS + 1);
    localparam logic [LW-1:0] QCAP = LW'(QUARTER_TICKS);

    logic [LW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_por_n) begin
        if (!rst_por_n)
            low_run <= '0;
        else if (host_rst_n)
            low_run <= '0;
        else if (low_run != QCAP)
            low_run <= low_run + 1'b1;
    end

    // R1
    always_comb begin
        if (!rst_por_n)
            por_hold_chk: assert (!host_rst_n);
    end

    // R1
    release_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        $rose(host_rst_n) |-> (low_run == QCAP));

    // R2
    supply_hold_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        supply_low |=> !host_rst_n);

    // R5
    wdt_off_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        (host_rst_n && !supply_low && wdt_sel == 2'b11) |=> host_rst_n);

    // R6
    kick_restart_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        (host_rst_n && !supply_low && wdt_kick) |=> host_rst_n);

    // R7
    sel_restart_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
        (host_rst_n && !supply_low && wdt_sel != $past(wdt_sel)) |=> host_rst_n);
endmodule

bind reset_supervisor reset_supervisor_chk #(.QUARTER_TICKS(QUARTER_TICKS)) u_chk (
    .clk        (clk),
    .rst_por_n  (rst_por_n),
    .supply_low (supply_low),
    .wdt_kick   (wdt_kick),
    .wdt_sel    (wdt_sel),
    .host_rst_n (host_rst_n)
);

// File: tb/reset_supervisor_test.sv
`timescale 1ns/1ps
module reset_supervisor_test;
    localparam int unsigned Q = 10;
    localparam int unsigned ROWS = 6;
    // {select, units}; units 0 means no bite expected
    localparam logic [9:0] VEC [ROWS] = '{
        {2'b00, 8'd7}, {2'b01, 8'd3}, {2'b10, 8'd1},
        {2'b11, 8'd0}, {2'b10, 8'd1}, {2'b01, 8'd3}
    };

    logic       clk = 1'b0;
    logic       rst_por_n = 1'b0;
    logic       supply_low = 1'b0;
    logic       wdt_kick = 1'b0;
    logic [1:0] wdt_sel = 2'b10;
    logic       host_rst_n;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    reset_supervisor #(.QUARTER_TICKS(Q)) uut (
        .clk        (clk),
        .rst_por_n  (rst_por_n),
        .supply_low (supply_low),
        .wdt_kick   (wdt_kick),
        .wdt_sel    (wdt_sel),
        .host_rst_n (host_rst_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // edges after a restart until host reset is seen low
    task automatic edges_to_low(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk); #1;
            n++;
            wdt_kick = 1'b0;
            if (!host_rst_n) return;
        end
        n = -1;
    endtask

    task automatic edges_to_high(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk); #1;
            n++;
            if (host_rst_n) return;
        end
        n = -1;
    endtask

    // called just after low was first seen
    task automatic pulse_len(output int len);
        len = 1;
        for (int i = 0; i < 1000; i++) begin
            @(posedge clk); #1;
            if (host_rst_n) return;
            len++;
        end
    endtask

    initial begin
        int n, len;
        bit bad;

        repeat (3) @(posedge clk);
        #1 chk("R1 held during power-on", host_rst_n, 0);

        @(negedge clk) rst_por_n = 1'b1;
        edges_to_high(200, n);
        chk("R1 power-on delay edges", n, Q);
        edges_to_low(200, len);
        chk("R9 first bite after release", n + len, 2 * Q);
        pulse_len(len);
        chk("R8 bite pulse width", len, Q);

        for (int r = 0; r < ROWS; r++) begin
            @(negedge clk);
            wdt_sel  = VEC[r][9:8];
            wdt_kick = 1'b1;
            if (VEC[r][7:0] == 0) begin
                edges_to_low(100, n);
                chk("R5 disabled code never bites", n, -1);
            end else begin
                edges_to_low(200, n);
                chk("R4 timeout for select", n, int'(VEC[r][7:0]) * Q + 1);
                pulse_len(len);
                chk("R8 pulse after bite", len, Q);
            end
        end

        // supply-low hold and re-delay
        @(negedge clk) supply_low = 1'b1;
        @(posedge clk); #1;
        chk("R2 reset on supply low", host_rst_n, 0);
        repeat (40) @(posedge clk);
        #1 chk("R2 still held", host_rst_n, 0);
        @(negedge clk) supply_low = 1'b0;
        edges_to_high(200, n);
        chk("R3 delay after supply recovers", n, Q + 1);

        // kick train keeps the short watchdog quiet
        bad = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            wdt_sel  = 2'b10;
            wdt_kick = 1'b1;
            @(negedge clk) wdt_kick = 1'b0;
            if (!host_rst_n) bad = 1'b1;
            repeat (3) begin
                @(negedge clk);
                if (!host_rst_n) bad = 1'b1;
            end
        end
        chk("R6 kicks prevent bite", bad, 0);
        @(negedge clk) wdt_kick = 1'b1;
        edges_to_low(200, n);
        chk("R6 bite after last kick", n, Q + 1);
        pulse_len(len);

        // shortening the period restarts the count
        @(negedge clk);
        wdt_sel  = 2'b01;
        wdt_kick = 1'b1;
        @(posedge clk); #1 wdt_kick = 1'b0;
        repeat (20) @(posedge clk);
        #1 chk("R7 no bite yet on long period", host_rst_n, 1);
        @(negedge clk) wdt_sel = 2'b10;
        edges_to_low(200, n);
        chk("R7 restart on select change", n, Q + 1);
        pulse_len(len);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        tests++;
        fails++;
        $display("FAIL watchdog: bench hung, got 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule